// File: doc/BRIEF.md
# Highpass-Shaped Dither Injector

This block adds a small pseudo-random dither to a stream of 16-bit two's complement samples. The samples arrive at the converter update rate, after interpolation and before the word is cut down to the converter's resolution. The noise comes from a maximal-length shift-register generator. A first-difference stage then shapes it, so it has no energy at DC and most of its energy near half the output sample rate, well away from the wanted band. A 3-bit amplitude setting attenuates the shaped noise by a power of two. The scaled dither is added to the sample with saturation.

A disable input lets the samples pass unchanged. Even while disabled, the noise state and the differencing history still move with every valid sample, so the noise keeps running and re-enabling it needs no restart. The output is registered once, and the output valid strobe is the input valid strobe delayed by one cycle.

Top module: `dither_hp_adder`

## Requirements
- R1: While reset is asserted (active-low `rst_n`) and after its release, until the first valid sample, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals `in_valid` one clock later. The result for a valid sample appears on `out_data` on the clock edge that samples it.
- R3: In a cycle with `in_valid` low, `out_data` keeps its value and the noise state does not advance. The dither sequence resumes exactly where it stopped.
- R4: With `dith_en` low, a valid sample appears on `out_data` unchanged.
- R5: The noise state is a 23-bit register. It is seeded to 1 by reset, never becomes zero, and on each valid sample takes the value {s[21:0], s[22] xor s[17]}, whatever the state of `dith_en`.
- R6: The raw noise r[n] is the low 8 bits of the state before its advance, read as two's complement. The shaped dither is d[n] = r[n] - r[n-1], with r[-1] = 0 after reset. The history r[n-1] updates on every valid sample, including disabled ones.
- R7: The added value is d[n] arithmetically shifted right by `dith_amp` (0 to 7), which rounds toward minus infinity.
- R8: The sum of sample and scaled dither clamps to the range -32768 to 32767 and never wraps.
- R9: The shaped dither has no DC content. With input 0 and `dith_amp` 0, the dither summed over any run of consecutive valid samples stays within -255 to 255.
- R10: With dither enabled, |out_data - in_data| never exceeds 256 >> `dith_amp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dith_en | input | 1 | 1 adds dither, 0 passes samples through |
| dith_amp | input | 3 | Attenuation: right-shift count for the shaped dither |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | Output strobe, in_valid delayed one cycle |
| out_data | output | 16 | Dithered, saturated sample |

## Verification
The assertions check on every cycle that the strobe follows its input one cycle later, that the output holds and the noise register stays frozen in idle cycles, and that disabled samples pass through exactly. They also check that the noise register never reaches zero, and that every dithered output lies within the shift-dependent distance of its input, which also rules out wrap-around. Only the bench scenarios can show the exact dither values: the bench model tracks the generator and difference history across idle gaps, amplitude changes and disabled stretches. Only those scenarios can show the telescoping sum that proves the zero at DC, and clamping exactly at the rails.

// File: rtl/dith_pkg.sv
package dith_pkg;
   // Default generator length and feedback mask (bits 22 and 17)
   localparam int unsigned GEN_W_DEF   = 23;
   localparam logic [22:0] GEN_TAP_DEF = 23'h420000;

   // Largest deviation of an output from its input for a given shift
   function automatic int unsigned dev_limit(input int unsigned noise_w,
                                             input int unsigned shamt);
      return (32'd1 << noise_w) >> shamt;
   endfunction
endpackage

// File: rtl/dith_lfsr.sv
module dith_lfsr #(
   parameter int unsigned GEN_W   = 23,
   parameter logic [GEN_W-1:0] TAPS = 23'h420000,
   parameter logic [GEN_W-1:0] SEED = 23'h1,
   parameter int unsigned NOISE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   output logic [NOISE_W-1:0] noise
);
   logic [GEN_W-1:0] state;
   logic             fb;

   if (GEN_W < 3) begin : g_bad_len
      $error("dith_lfsr: GEN_W too small");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("dith_lfsr: zero seed locks the generator");
   end
   if (!TAPS[GEN_W-1]) begin : g_bad_taps
      $error("dith_lfsr: top bit must be a feedback tap");
   end
   if (NOISE_W > GEN_W) begin : g_bad_noise
      $error("dith_lfsr: NOISE_W exceeds GEN_W");
   end

   assign fb = ^(state & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state <= SEED;
      else if (adv) state <= {state[GEN_W-2:0], fb};
   end

   assign noise = state[NOISE_W-1:0];

   // R5
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
   // R3
   lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(state));
   // R5
   lfsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> state[GEN_W-1:1] == $past(state[GEN_W-2:0]));
endmodule

// File: rtl/dith_hpdiff.sv
module dith_hpdiff #(
   parameter int unsigned NOISE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      adv,
   input  logic [NOISE_W-1:0]        noise,
   output logic signed [NOISE_W:0]   diff
);
   logic signed [NOISE_W-1:0] r_cur;
   logic signed [NOISE_W-1:0] r_hist;

   if (NOISE_W < 2) begin : g_bad_w
      $error("dith_hpdiff: NOISE_W too small");
   end

   assign r_cur = $signed(noise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r_hist <= '0;
      else if (adv) r_hist <= r_cur;
   end

   // First difference: zero at DC, peak gain at half the sample rate
   assign diff = {r_cur[NOISE_W-1], r_cur} - {r_hist[NOISE_W-1], r_hist};

   // R6
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(r_hist));
endmodule

// File: rtl/dith_satadd.sv
module dith_satadd #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned NOISE_W = 8,
   parameter int unsigned AMP_W   = 3
) (
   input  logic                     en,
   input  logic [AMP_W-1:0]         amp,
   input  logic [DATA_W-1:0]        din,
   input  logic signed [NOISE_W:0]  diff,
   output logic [DATA_W-1:0]        dout
);
   localparam int unsigned SUM_W = DATA_W + 1;

   logic signed [NOISE_W:0] scaled;
   logic signed [SUM_W-1:0] addend;
   logic signed [SUM_W-1:0] sum;
   logic                    ovf;

   if (NOISE_W + 2 > DATA_W) begin : g_bad_w
      $error("dith_satadd: dither too wide for data path");
   end

   assign scaled = diff >>> amp;
   assign addend = en ? SUM_W'(scaled) : '0;
   assign sum    = $signed({din[DATA_W-1], din}) + addend;
   assign ovf    = sum[SUM_W-1] ^ sum[DATA_W-1];
   assign dout   = ovf ? {sum[SUM_W-1], {(DATA_W-1){~sum[SUM_W-1]}}}
                        : sum[DATA_W-1:0];
endmodule

// File: rtl/dither_hp_adder.sv
module dither_hp_adder #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned GEN_W   = dith_pkg::GEN_W_DEF,
   parameter logic [GEN_W-1:0] GEN_TAPS = dith_pkg::GEN_TAP_DEF,
   parameter logic [GEN_W-1:0] GEN_SEED = 1,
   parameter int unsigned NOISE_W = 8,
   parameter int unsigned AMP_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dith_en,
   input  logic [AMP_W-1:0]  dith_amp,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int DEV_MAX = int'(dith_pkg::dev_limit(NOISE_W, 0));

   logic [NOISE_W-1:0]      noise;
   logic signed [NOISE_W:0] diff;
   logic [DATA_W-1:0]       mixed;

   if (DATA_W > 31) begin : g_bad_data
      $error("dither_hp_adder: DATA_W above 31 not supported");
   end

   dith_lfsr #(.GEN_W(GEN_W), .TAPS(GEN_TAPS), .SEED(GEN_SEED),
               .NOISE_W(NOISE_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .noise(noise));

   dith_hpdiff #(.NOISE_W(NOISE_W)) u_hp (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .noise(noise), .diff(diff));

   dith_satadd #(.DATA_W(DATA_W), .NOISE_W(NOISE_W), .AMP_W(AMP_W)) u_add (
      .en(dith_en), .amp(dith_amp), .din(in_data), .diff(diff), .dout(mixed));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= mixed;
      end
   end

   function automatic int sx(input logic [DATA_W-1:0] v);
      return int'($signed(v));
   endfunction

   // R2
   strobe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
   // R4
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !dith_en |=> out_data == $past(in_data));
   // R10 (and R8: a wrapped sum would break this bound)
   dev_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && dith_en |=>
         (sx(out_data) - sx($past(in_data)) <= (DEV_MAX >> $past(dith_amp))) &&
         (sx($past(in_data)) - sx(out_data) <= (DEV_MAX >> $past(dith_amp))));
endmodule

// File: tb/sim_dither_hp_adder.sv
module sim_dither_hp_adder;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dith_en = 1'b0;
   logic [2:0]  dith_amp = '0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_data;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference model state
   logic [22:0] m_gen;
   int          m_prev;
   int          m_out;
   bit          m_ov;

   always #(CLK_PERIOD/2) clk = ~clk;

   dither_hp_adder u0 (
      .clk(clk), .rst_n(rst_n), .dith_en(dith_en), .dith_amp(dith_amp),
      .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   function automatic int s16(input logic [15:0] v);
      return int'($signed(v));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the following negedge
   task automatic step(input bit v, input int d, input bit e, input int a,
                       input string tag);
      int r, dd, sc, sum;
      in_valid = v; in_data = d[15:0]; dith_en = e; dith_amp = a[2:0];
      @(posedge clk);
      if (v) begin
         r   = int'($signed(m_gen[7:0]));
         dd  = r - m_prev;
         sc  = dd >>> a;
         sum = s16(d[15:0]) + (e ? sc : 0);
         if (sum > 32767)  sum = 32767;
         if (sum < -32768) sum = -32768;
         m_out  = sum;
         m_prev = r;
         m_gen  = {m_gen[21:0], m_gen[22] ^ m_gen[17]};
      end
      m_ov = v;
      @(negedge clk);
      check({tag, " R2 valid"}, int'(out_valid), int'(m_ov));
      check({tag, " data"}, s16(out_data), m_out);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int acc, a0;
      m_gen = 23'h1; m_prev = 0; m_out = 0; m_ov = 0;
      repeat (3) @(negedge clk);
      // R1: during reset
      check("R1 valid in reset", int'(out_valid), 0);
      check("R1 data in reset", s16(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", int'(out_valid), 0);
      check("R1 data after reset", s16(out_data), 0);

      // R4: bypass, also advances noise history (R5 R6)
      for (int i = 0; i < 20; i++)
         step(1, int'($urandom) & 16'hFFFF, 0, int'($urandom % 8), "R4 bypass");
      // R6: first enabled sample after a disabled stretch
      step(1, 1000, 1, 0, "R6 resume");

      // R7 R5 R6 R10: every shift setting
      for (int a = 0; a < 8; a++)
         for (int i = 0; i < 30; i++) begin
            int d = int'($urandom % 40000) - 20000;
            step(1, d, 1, a, "R7 R5 amp");
            total++;
            a0 = s16(out_data) - d;
            if (a0 > (256 >> a) || -a0 > (256 >> a)) begin
               bad++;
               $display("FAIL R10 actual=%0d expected=|x|<=%0d", a0, 256 >> a);
            end
         end

      // R3: gaps in the valid strobe
      for (int i = 0; i < 60; i++)
         step(($urandom % 3) != 0, int'($urandom % 30000) - 15000, 1,
              int'($urandom % 3), "R3 gaps");

      // R8: rails
      for (int i = 0; i < 30; i++) step(1, 32767, 1, 0, "R8 top rail");
      for (int i = 0; i < 30; i++) step(1, -32768, 1, 0, "R8 bottom rail");
      for (int i = 0; i < 30; i++) step(1, 32700, 1, 0, "R8 near top");
      for (int i = 0; i < 20; i++) step(1, -32700, 1, 1, "R8 near bottom");

      // R9: no DC content
      acc = 0;
      for (int i = 0; i < 300; i++) begin
         step(1, 0, 1, 0, "R9 dc");
         acc += s16(out_data);
         if (i % 50 == 49) begin
            total++;
            if (acc > 255 || acc < -255) begin
               bad++;
               $display("FAIL R9 actual=%0d expected=|sum|<=255", acc);
            end
         end
      end

      // R3: long idle, output must hold
      for (int i = 0; i < 10; i++) step(0, 12345, 1, 0, "R3 idle");
      step(1, -5, 1, 2, "R3 after idle");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule